// File: doc/BRIEF.md
# Wake Frame Pattern Detector

This block sits on a receive byte stream and looks for a wake frame: a frame whose payload carries the station's 48-bit address sixteen times in a row. The run of copies may start at any payload position but must be complete before the frame check sequence. The first byte of a frame carries a start marker, the last byte carries an end marker, and the trailing check bytes carry a separate marker. Payload is every byte from header offset 14 onward (the byte with the start marker is offset 0) that does not carry the check-sequence marker.

A control bit chooses how the destination address is screened. Either the six destination bytes must equal the station address, or any unicast, multicast or broadcast destination is accepted. The detector is armed only when its mode enable is set and either the sleep input or the software enable is high. While armed, every received frame is flushed upstream through a discard output. A detection sets a sticky flag that software clears. The flag drives an interrupt through two enables and a selectable indicator pin with programmable polarity.

Top module: `wol_wake_detect`

## Requirements
- R1: `rx_discard` is high in exactly those cycles where `wake_mode_en` is 1 and at least one of `sleep_req` or `sw_wake_en` is 1.
- R2: When armed, a frame whose payload holds 16 back-to-back copies of `station_addr` sets `wake_flag` on the clock edge that samples the last pattern byte. Each copy is sent most significant byte first (`station_addr[47:40]` first, `[7:0]` last).
- R3: The copies may begin at any payload offset. A partial copy of the address directly before the true run does not hide the run.
- R4: Only payload bytes count. A pattern that reaches into the check-sequence bytes does not set the flag, and neither does one that begins inside the 14-byte header.
- R5: A single flipped bit anywhere in the 96 pattern bytes prevents detection.
- R6: With `any_dest` = 0, frame bytes 0 to 5 must equal `station_addr` (most significant byte first). With `any_dest` = 1, any destination is accepted, including ones with the group bit set.
- R7: When not armed, no frame sets `wake_flag`.
- R8: `wake_flag` is 0 after reset and holds until `flag_clr` is sampled high. If a detection and a clear fall on the same edge, the detection wins.
- R9: `wake_irq` equals `wake_flag` AND `glob_irq_en` AND `wake_irq_en`.
- R10: `wake_ind` follows the term A = `wake_flag` AND `ind_wake_sel` AND NOT `ind_rx_act`. It equals A when `ind_active_high` = 1 and NOT A when it is 0.
- R11: The destination check and the match progress restart at every start marker, so an earlier frame's rejected destination or partial run does not carry into the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_fcs | input | 1 | Byte belongs to the check sequence |
| station_addr | input | 48 | Station address, bits 47:40 sent first |
| wake_mode_en | input | 1 | Wake detection mode enable |
| sleep_req | input | 1 | Hardware sleep request |
| sw_wake_en | input | 1 | Software arm bit |
| any_dest | input | 1 | Accept any destination address |
| glob_irq_en | input | 1 | Global interrupt enable |
| wake_irq_en | input | 1 | Detection interrupt enable |
| flag_clr | input | 1 | Clear the sticky flag |
| ind_wake_sel | input | 1 | Route detection to indicator |
| ind_rx_act | input | 1 | Indicator shows receive activity instead |
| ind_active_high | input | 1 | Indicator polarity |
| wake_flag | output | 1 | Sticky detection flag |
| wake_irq | output | 1 | Interrupt request |
| wake_ind | output | 1 | Indicator pin |
| rx_discard | output | 1 | Flush received frames while armed |

## Verification
On every cycle, the assertions check the output decoding (discard, interrupt, indicator polarity) and the flag's life cycle. They check that the flag rises only after an armed, non-check-sequence byte and that it holds or clears as commanded. Whether a frame really carries sixteen aligned copies cannot be seen in a single cycle. The bench's frame scenarios cover that: placement at odd offsets, a partial copy before the run, a run that reaches into the check sequence or starts in the header, single-bit corruption, the two destination modes and a run split across two frames. A scanning model in the bench predicts each outcome.

// File: rtl/wol_pkg.sv
package wol_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;

    // byte idx of an address, idx 0 being the first byte on the wire
    function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a, input int idx);
        return a[ADDR_W-1-8*idx -: 8];
    endfunction
endpackage

// File: rtl/wol_frame_track.sv
module wol_frame_track
    import wol_pkg::*;
#(
    parameter int HDR_BYTES = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_fcs,
    input  logic [7:0]        rx_data,
    input  logic [ADDR_W-1:0] station_addr,
    output logic              take,
    output logic              payload,
    output logic              da_match
);
    localparam int PW = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic          in_frame;
        logic [PW-1:0] pos;
        logic          da_ok;
    } trk_t;

    trk_t          q, d;
    logic [PW-1:0] pos_cur;
    logic          da_byte_ok;

    always_comb begin
        d          = q;
        take       = rx_valid && (rx_sof || q.in_frame);
        pos_cur    = rx_sof ? '0 : q.pos;
        payload    = take && (pos_cur == PW'(HDR_BYTES)) && !rx_fcs;
        da_byte_ok = (int'(pos_cur) < ADDR_BYTES) ?
                     (rx_data == pick_byte(station_addr, int'(pos_cur))) : 1'b1;
        if (take) begin
            d.in_frame = !rx_eof;
            d.pos      = (pos_cur == PW'(HDR_BYTES)) ? pos_cur : pos_cur + 1'b1;
            d.da_ok    = (rx_sof ? 1'b1 : q.da_ok) && da_byte_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign da_match = q.da_ok;
endmodule

// File: rtl/wol_run_match.sv
module wol_run_match
    import wol_pkg::*;
#(
    parameter int REPS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              sof,
    input  logic              payload,
    input  logic [7:0]        data,
    input  logic [ADDR_W-1:0] addr,
    output logic              reps_done
);
    localparam int CW = $clog2(REPS + 1);
    localparam int RW = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]                win;
        logic [RW-1:0]                    run;
        logic [ADDR_BYTES-1:0][CW-1:0]    ring;
    } mt_t;

    mt_t                   q, d;
    logic [ADDR_W-1:0]     win_nx;
    logic [ADDR_BYTES-1:0] byte_eq;
    logic [RW-1:0]         run_nx;
    logic                  full_copy;
    logic [CW-1:0]         cnt_nx;

    assign win_nx = {q.win[ADDR_W-9:0], data};

    // compare the last six bytes against the address, one lane per byte
    for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_lane
        assign byte_eq[i] = (win_nx[8*i +: 8] == addr[8*i +: 8]);
    end

    always_comb begin
        d         = q;
        run_nx    = payload ? ((q.run == RW'(ADDR_BYTES)) ? q.run : q.run + 1'b1) : '0;
        full_copy = payload && (run_nx == RW'(ADDR_BYTES)) && (&byte_eq);
        // copies ending six bytes apart chain into a run
        cnt_nx    = !full_copy ? '0 :
                    ((q.ring[ADDR_BYTES-1] == CW'(REPS)) ? CW'(REPS)
                                                         : q.ring[ADDR_BYTES-1] + 1'b1);
        reps_done = take && (cnt_nx == CW'(REPS));
        if (take) begin
            d.win     = win_nx;
            d.run     = sof ? '0 : run_nx;
            d.ring[0] = sof ? '0 : cnt_nx;
            for (int i = 1; i < ADDR_BYTES; i++)
                d.ring[i] = sof ? '0 : q.ring[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wol_wake_detect.sv
module wol_wake_detect
    import wol_pkg::*;
#(
    parameter int REPS      = 16,
    parameter int HDR_BYTES = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        rx_fcs,
    input  logic [47:0] station_addr,
    input  logic        wake_mode_en,
    input  logic        sleep_req,
    input  logic        sw_wake_en,
    input  logic        any_dest,
    input  logic        glob_irq_en,
    input  logic        wake_irq_en,
    input  logic        flag_clr,
    input  logic        ind_wake_sel,
    input  logic        ind_rx_act,
    input  logic        ind_active_high,
    output logic        wake_flag,
    output logic        wake_irq,
    output logic        wake_ind,
    output logic        rx_discard
);
    typedef struct packed {
        logic flag;
    } top_t;

    top_t q, d;
    logic take, payload, da_match, reps_done, armed, hit, ind_act;

    wol_frame_track #(.HDR_BYTES(HDR_BYTES)) u_trk (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_fcs(rx_fcs), .rx_data(rx_data),
        .station_addr(station_addr), .take(take), .payload(payload),
        .da_match(da_match)
    );

    wol_run_match #(.REPS(REPS)) u_match (
        .clk(clk), .rst_n(rst_n), .take(take), .sof(rx_sof),
        .payload(payload), .data(rx_data), .addr(station_addr),
        .reps_done(reps_done)
    );

    always_comb begin
        armed   = wake_mode_en && (sleep_req || sw_wake_en);
        hit     = armed && payload && reps_done && (any_dest || da_match);
        d       = q;
        if (hit)           d.flag = 1'b1;
        else if (flag_clr) d.flag = 1'b0;
        ind_act = q.flag && ind_wake_sel && !ind_rx_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wake_flag  = q.flag;
    assign wake_irq   = q.flag && glob_irq_en && wake_irq_en;
    assign wake_ind   = ind_active_high ? ind_act : !ind_act;
    assign rx_discard = armed;
endmodule

// File: rtl/wol_wake_detect_chk.sv
module wol_wake_detect_chk (
    input logic clk, rst_n, rx_valid, rx_fcs,
    input logic wake_mode_en, sleep_req, sw_wake_en,
    input logic glob_irq_en, wake_irq_en, flag_clr,
    input logic ind_wake_sel, ind_rx_act, ind_active_high,
    input logic wake_flag, wake_irq, wake_ind, rx_discard
);
    p_discard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_discard == (wake_mode_en && (sleep_req || sw_wake_en)));

    p_armed_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(wake_mode_en && (sleep_req || sw_wake_en)));

    p_payload_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> $past(rx_valid && !rx_fcs));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !flag_clr) |=> wake_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !rx_valid) |=> !wake_flag);

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq == (wake_flag && glob_irq_en && wake_irq_en));

    p_ind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ind == (ind_active_high == (wake_flag && ind_wake_sel && !ind_rx_act)));
endmodule

bind wol_wake_detect wol_wake_detect_chk u_chk (.*);

// File: tb/wol_wake_detect_tb.sv
module wol_wake_detect_tb;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_fcs = 0;
    logic [7:0] rx_data = 0;
    logic [47:0] station_addr = 48'h0;
    logic wake_mode_en = 1, sleep_req = 1, sw_wake_en = 0, any_dest = 0;
    logic glob_irq_en = 0, wake_irq_en = 0, flag_clr = 0;
    logic ind_wake_sel = 0, ind_rx_act = 0, ind_active_high = 0;
    logic wake_flag, wake_irq, wake_ind, rx_discard;

    int n_chk = 0, n_fail = 0;
    logic [7:0] fbuf [0:255];
    int flen;

    always #(CLK_P/2) clk = ~clk;

    wol_wake_detect u_dut (.*);

    function automatic logic [7:0] abyte(input logic [47:0] a, input int k);
        return a[47-8*(k%6) -: 8];
    endfunction

    function automatic bit model_hit(input logic [47:0] a, input bit anyd, input bit arm);
        bit ok;
        if (!arm) return 0;
        if (!anyd)
            for (int i = 0; i < 6; i++) if (fbuf[i] != abyte(a, i)) return 0;
        for (int o = 14; o + 96 <= flen - 4; o++) begin
            ok = 1;
            for (int k = 0; k < 96; k++) if (fbuf[o+k] != abyte(a, k)) ok = 0;
            if (ok) return 1;
        end
        return 0;
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic build(input logic [47:0] a, input bit da_self, input int plen);
        flen = 14 + plen + 4;
        for (int i = 0; i < flen; i++) fbuf[i] = 8'($urandom);
        if (da_self) for (int i = 0; i < 6; i++) fbuf[i] = abyte(a, i);
    endtask

    task automatic put_pat(input logic [47:0] a, input int start, input int nbytes);
        for (int k = 0; k < nbytes; k++)
            if (start + k < flen) fbuf[start+k] = abyte(a, k);
    endtask

    task automatic send;
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_data = fbuf[i];
            rx_sof = (i == 0); rx_eof = (i == flen-1); rx_fcs = (i >= flen-4);
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs = 0;
    endtask

    task automatic clr;
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    task automatic run_frame(input string tag, input bit exp);
        clr;
        send;
        check(wake_flag, exp, tag);
    endtask

    logic [47:0] A;

    initial begin
        #(CLK_P*150000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        A = 48'h02_1A_7C_33_E5_90;
        station_addr = A;
        repeat (3) @(negedge clk);
        // R8 reset state, R10 idle low-active indicator is high
        check(wake_flag, 0, "R8 reset flag");
        check(wake_irq, 0, "R9 reset irq");
        check(wake_ind, 1, "R10 reset ind");
        rst_n = 1;
        @(negedge clk);

        // R2 basic detection at payload offset 0
        build(A, 1, 120); put_pat(A, 14, 96);
        run_frame("R2 basic", 1);
        // R3 odd offset
        build(A, 1, 160); put_pat(A, 14+37, 96);
        run_frame("R3 offset 37", 1);
        // R3 partial copy directly before the run
        build(A, 1, 170); put_pat(A, 20, 60); put_pat(A, 20+63, 3); put_pat(A, 20+66, 96);
        run_frame("R3 partial prefix", 1);
        // R4 run reaching into check bytes
        build(A, 1, 100); put_pat(A, 14+6, 96);
        run_frame("R4 into FCS", 0);
        // R4 run starting in header
        build(A, 1, 120); put_pat(A, 8, 96);
        run_frame("R4 from header", 0);
        // R5 single bit flip
        build(A, 1, 130); put_pat(A, 30, 96); fbuf[30+50] ^= 8'h10;
        run_frame("R5 bit flip", 0);
        // R6 destination mismatch in strict mode, accepted in any mode
        build(A, 0, 120); fbuf[0] = 8'hFF; put_pat(A, 14, 96);
        run_frame("R6 strict mismatch", 0);
        any_dest = 1;
        run_frame("R6 any dest multicast", 1);
        any_dest = 0;
        // R11 bad destination in previous frame does not leak
        build(A, 1, 120); put_pat(A, 14, 96);
        run_frame("R11 DA restart", 1);
        // R11 run split over two frames
        build(A, 1, 60); put_pat(A, 14+12, 48);
        run_frame("R11 split part1", 0);
        build(A, 1, 60); put_pat(A, 14, 48);
        run_frame("R11 split part2", 0);
        // R7 not armed
        wake_mode_en = 0; @(negedge clk);
        check(rx_discard, 0, "R1 discard off");
        build(A, 1, 120); put_pat(A, 14, 96);
        run_frame("R7 disarmed", 0);
        wake_mode_en = 1; sleep_req = 0; sw_wake_en = 1; @(negedge clk);
        check(rx_discard, 1, "R1 discard sw");
        run_frame("R7 sw armed", 1);
        sleep_req = 1; sw_wake_en = 0;
        // R8 sticky through a plain frame
        build(A, 1, 80);
        send;
        check(wake_flag, 1, "R8 sticky");
        // R9 and R10 decoding with flag set
        for (int c = 0; c < 4; c++) begin
            glob_irq_en = c[0]; wake_irq_en = c[1]; @(negedge clk);
            check(wake_irq, c == 3, "R9 irq combo");
        end
        for (int c = 0; c < 8; c++) begin
            ind_wake_sel = c[0]; ind_rx_act = c[1]; ind_active_high = c[2]; @(negedge clk);
            check(wake_ind, c[2] ? (c[0] && !c[1]) : !(c[0] && !c[1]), "R10 ind combo");
        end
        clr;
        check(wake_flag, 0, "R8 clear");

        // random frames against the bench model (R2 R3 R4 R5 R6 R7)
        for (int it = 0; it < 80; it++) begin
            bit arm, dself, anyd, e;
            int plen, off;
            A = ($urandom_range(0, 3) == 0) ? {6{8'($urandom)}} : {16'($urandom), 32'($urandom)};
            station_addr = A;
            arm = ($urandom_range(0, 4) != 0);
            wake_mode_en = arm; sleep_req = $urandom_range(0, 1); sw_wake_en = !sleep_req;
            dself = ($urandom_range(0, 9) < 7);
            anyd = $urandom_range(0, 1); any_dest = anyd;
            plen = $urandom_range(90, 220);
            build(A, dself, plen);
            if ($urandom_range(0, 4) != 0) begin
                off = $urandom_range(0, plen - 90);
                put_pat(A, 14 + off, 96);
                if ($urandom_range(0, 4) == 0) fbuf[14 + off + $urandom_range(0, 95)] ^= 8'(1 << $urandom_range(0, 7));
            end
            e = model_hit(A, anyd, arm);
            run_frame("R2 random frame", e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule